// File: doc/BRIEF.md
# Pin Drive Waveform Formatter

This block shapes the drive waveform of a single tester pin for each test cycle. When the timing generator pulses the cycle-start input, the block captures one drive data bit, a direction bit, a three-bit format code, the cycle length, and two edge selectors. Each selector picks one of the phase times on a shared phase-time bus. The first selected time is the assert edge and the second is the return edge. Both are counts of fast-clock ticks from the start of the cycle.

A tick counter is cleared at each cycle start. An edge has fired once the counter has reached its time, provided that time is shorter than the cycle length. The format then decides the pin level and the driver enable in each tick:

- Non-return holds the last value driven.
- Return to 1, return to 0 and return to hi-Z show the data only inside the window between the two edges.
- Return to complement and complement surround show the inverted data outside that window.

A direction bit of 0 makes the cycle an input cycle, and the driver stays off for the whole cycle. A separate static mode overrides all per-cycle formatting and drives a fixed high, low or high-impedance state.

Top module: `pin_wave_fmt`

## Requirements
- R1: While reset is held, and after it until a cycle or static level is applied, pin_oe and pin_lvl are both 0.
- R2: A cycle_start sampled at a clock edge latches all cyc_* inputs and the selected phase times. The tick counter reads 0 in the following clock period and then rises by one per clock, saturating at its maximum. pin_oe/pin_lvl show the state of tick t one clock after the counter holds t.
- R3: cyc_asel and cyc_rsel pick phase k, which is phase_times[k*TICK_W +: TICK_W]. An edge counts as fired in every tick whose count is greater than or equal to its time.
- R4: When cyc_out_en is 0 (input cycle), pin_oe is 0 for every tick of that cycle.
- R5: Format code 0 (non-return): once the assert edge has fired the pin drives the cycle's data. Before that it drives the held value, which is the data of the most recent output cycle whose assert edge fired (0 after reset). The return edge has no effect.
- R6: Format codes 1 and 2 (return to 1 / return to 0) drive the data inside the window and drive 1 or 0 respectively outside it. The window is the set of ticks where the assert edge has fired and the return edge has not.
- R7: Format code 3 (return to hi-Z) enables the driver only inside the window, and drives the data there.
- R8: Format codes 4 and 5 (return to complement / complement surround) drive the data inside the window and its inverse both before the window and after it.
- R9: Format codes 6 and 7 behave exactly as code 0.
- R10: While static_en is 1, each clock the outputs follow static_sel: 00 drives low, 01 drives high, 1x is high impedance. Cycle inputs have no effect on the pin.
- R11: Whenever pin_oe is 0, pin_lvl is 0.
- R12: An edge whose time is equal to or greater than the latched cycle length never fires in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | Cycle-start pulse from the timing generator |
| cyc_len | input | TICK_W | Cycle length in ticks |
| phase_times | input | PHASE_N*TICK_W | Phase times of the active timing set, phase k in slice k |
| cyc_data | input | 1 | Drive data bit of the cycle |
| cyc_out_en | input | 1 | 1 = output cycle, 0 = input cycle |
| cyc_fmt | input | 3 | Format code of the cycle |
| cyc_asel | input | $clog2(PHASE_N) | Phase index of the assert edge |
| cyc_rsel | input | $clog2(PHASE_N) | Phase index of the return edge |
| static_en | input | 1 | Static mode enable |
| static_sel | input | 2 | Static level: 00 low, 01 high, 1x hi-Z |
| pin_lvl | output | 1 | Logic level to drive |
| pin_oe | output | 1 | Driver enable, 0 = high impedance |

## Verification
Some rules hold in every clock and are checked by the assertions throughout the run:

- the static override of the outputs;
- the quiet level while the driver is off;
- the disabled driver in input cycles;
- the clearing and stepping of the tick counter.

The shape of each format cannot be checked that way, because it depends on sequences of cycles. This covers the edge positions inside a cycle, the value carried across cycles by non-return, the handling of codes 6 and 7, and edges at or beyond the cycle length. The bench scenarios show these by recording the pin in every tick and comparing it with values worked out by hand.

// File: rtl/pin_fmt_pkg.sv
package pin_fmt_pkg;

   typedef enum logic [2:0] {
      FMT_NR    = 3'd0,
      FMT_RET1  = 3'd1,
      FMT_RET0  = 3'd2,
      FMT_RETZ  = 3'd3,
      FMT_RETC  = 3'd4,
      FMT_SURR  = 3'd5,
      FMT_RSV6  = 3'd6,
      FMT_RSV7  = 3'd7
   } fmt_e;

   typedef struct packed {
      logic oe;
      logic lvl;
   } drive_t;

   localparam drive_t DRIVE_OFF = '{oe: 1'b0, lvl: 1'b0};

endpackage

// File: rtl/pin_fmt_phase_sel.sv
module pin_fmt_phase_sel #(
   parameter int TICK_W  = 8,
   parameter int PHASE_N = 4,
   localparam int SEL_W  = $clog2(PHASE_N)
) (
   input  logic [PHASE_N*TICK_W-1:0] times_i,
   input  logic [SEL_W-1:0]          sel_i,
   output logic [TICK_W-1:0]         time_o
);

   logic [TICK_W-1:0] slot [PHASE_N];

   for (genvar g = 0; g < PHASE_N; g++) begin : g_slot
      assign slot[g] = times_i[g*TICK_W +: TICK_W];
   end

   // an index past PHASE_N yields the largest time, which never fires
   always_comb begin
      time_o = '1;
      for (int k = 0; k < PHASE_N; k++) begin
         if (sel_i == SEL_W'(k)) time_o = slot[k];
      end
   end

endmodule

// File: rtl/pin_fmt_edge_timer.sv
module pin_fmt_edge_timer #(
   parameter int TICK_W = 8,
   parameter int EDGE_N = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic [TICK_W-1:0]        len_i,
   input  logic [EDGE_N*TICK_W-1:0] edge_t_i,
   output logic [TICK_W-1:0]        tick_o,
   output logic [EDGE_N-1:0]        passed_o
);

   localparam logic [TICK_W-1:0] TICK_MAX = '1;

   always_ff @(posedge clk) begin
      if (!rst_n)                tick_o <= '0;
      else if (start_i)          tick_o <= '0;
      else if (tick_o != TICK_MAX) tick_o <= tick_o + 1'b1;
   end

   for (genvar g = 0; g < EDGE_N; g++) begin : g_edge
      logic [TICK_W-1:0] t_at;
      logic              live;
      assign t_at        = edge_t_i[g*TICK_W +: TICK_W];
      assign live        = (t_at < len_i);
      assign passed_o[g] = live && (tick_o >= t_at);
   end

endmodule

// File: rtl/pin_fmt_shaper.sv
module pin_fmt_shaper
   import pin_fmt_pkg::*;
#(
   parameter bit RSV_AS_NR = 1'b1
) (
   input  fmt_e   fmt_i,
   input  logic   data_i,
   input  logic   asserted_i,
   input  logic   window_i,
   input  logic   hold_i,
   output drive_t drv_o
);

   always_comb begin
      drv_o = '{oe: 1'b1, lvl: 1'b0};
      unique case (fmt_i)
         FMT_NR:   drv_o.lvl = asserted_i ? data_i : hold_i;
         FMT_RET1: drv_o.lvl = window_i ? data_i : 1'b1;
         FMT_RET0: drv_o.lvl = window_i ? data_i : 1'b0;
         FMT_RETZ: begin
            drv_o.oe  = window_i;
            drv_o.lvl = window_i & data_i;
         end
         FMT_RETC, FMT_SURR: drv_o.lvl = window_i ? data_i : ~data_i;
         FMT_RSV6, FMT_RSV7: begin
            if (RSV_AS_NR) drv_o.lvl = asserted_i ? data_i : hold_i;
            else           drv_o     = DRIVE_OFF;
         end
         default: drv_o = DRIVE_OFF;
      endcase
   end

endmodule

// File: rtl/pin_wave_fmt.sv
module pin_wave_fmt
   import pin_fmt_pkg::*;
#(
   parameter int TICK_W    = 8,
   parameter int PHASE_N   = 4,
   parameter bit RSV_AS_NR = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cyc_start,
   input  logic [TICK_W-1:0]         cyc_len,
   input  logic [PHASE_N*TICK_W-1:0] phase_times,
   input  logic                      cyc_data,
   input  logic                      cyc_out_en,
   input  logic [2:0]                cyc_fmt,
   input  logic [$clog2(PHASE_N)-1:0] cyc_asel,
   input  logic [$clog2(PHASE_N)-1:0] cyc_rsel,
   input  logic                      static_en,
   input  logic [1:0]                static_sel,
   output logic                      pin_lvl,
   output logic                      pin_oe
);

   localparam int SEL_W = $clog2(PHASE_N);
   localparam int EDGE_N = 2;

   if (PHASE_N < 2) begin : g_bad_phase_n
      $error("pin_wave_fmt: PHASE_N must be at least 2");
   end
   if (TICK_W < 2) begin : g_bad_tick_w
      $error("pin_wave_fmt: TICK_W must be at least 2");
   end

   logic [TICK_W-1:0] ta_sel, tr_sel;
   logic [TICK_W-1:0] ta_q, tr_q, len_q;
   logic              data_q, dir_q, hold_q;
   fmt_e              fmt_q;
   logic [TICK_W-1:0] tick;
   logic [EDGE_N-1:0] passed;
   logic              asserted, window;
   drive_t            shaped;

   pin_fmt_phase_sel #(.TICK_W(TICK_W), .PHASE_N(PHASE_N)) u_sel_a (
      .times_i(phase_times), .sel_i(cyc_asel), .time_o(ta_sel));

   pin_fmt_phase_sel #(.TICK_W(TICK_W), .PHASE_N(PHASE_N)) u_sel_r (
      .times_i(phase_times), .sel_i(cyc_rsel), .time_o(tr_sel));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ta_q   <= '0;
         tr_q   <= '0;
         len_q  <= '0;
         data_q <= 1'b0;
         dir_q  <= 1'b0;
         fmt_q  <= FMT_NR;
      end else if (cyc_start) begin
         ta_q   <= ta_sel;
         tr_q   <= tr_sel;
         len_q  <= cyc_len;
         data_q <= cyc_data;
         dir_q  <= cyc_out_en;
         fmt_q  <= fmt_e'(cyc_fmt);
      end
   end

   pin_fmt_edge_timer #(.TICK_W(TICK_W), .EDGE_N(EDGE_N)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (cyc_start),
      .len_i    (len_q),
      .edge_t_i ({tr_q, ta_q}),
      .tick_o   (tick),
      .passed_o (passed));

   assign asserted = passed[0];
   assign window   = passed[0] & ~passed[1];

   // value carried into the next non-return cycle
   always_ff @(posedge clk) begin
      if (!rst_n)                           hold_q <= 1'b0;
      else if (!static_en && dir_q && asserted) hold_q <= data_q;
   end

   pin_fmt_shaper #(.RSV_AS_NR(RSV_AS_NR)) u_shape (
      .fmt_i      (fmt_q),
      .data_i     (data_q),
      .asserted_i (asserted),
      .window_i   (window),
      .hold_i     (hold_q),
      .drv_o      (shaped));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pin_oe  <= 1'b0;
         pin_lvl <= 1'b0;
      end else if (static_en) begin
         pin_oe  <= ~static_sel[1];
         pin_lvl <= ~static_sel[1] & static_sel[0];
      end else if (!dir_q) begin
         pin_oe  <= 1'b0;
         pin_lvl <= 1'b0;
      end else begin
         pin_oe  <= shaped.oe;
         pin_lvl <= shaped.oe & shaped.lvl;
      end
   end

endmodule

// File: rtl/pin_wave_fmt_chk.sv
module pin_wave_fmt_chk #(
   parameter int TICK_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cyc_start,
   input logic              static_en,
   input logic [1:0]        static_sel,
   input logic              pin_lvl,
   input logic              pin_oe,
   input logic              dir_q,
   input logic [TICK_W-1:0] tick
);

   localparam logic [TICK_W-1:0] TICK_MAX = '1;

   p_quiet_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_oe |-> !pin_lvl);

   p_static_hiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (static_en && static_sel[1]) |=> !pin_oe);

   p_static_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (static_en && !static_sel[1]) |=> (pin_oe && pin_lvl == $past(static_sel[0])));

   p_input_cycle_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!static_en && !dir_q) |=> !pin_oe);

   p_tick_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_start |=> (tick == '0));

   p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cyc_start && tick != TICK_MAX) |=> (tick == $past(tick) + 1'b1));

endmodule

bind pin_wave_fmt pin_wave_fmt_chk #(.TICK_W(TICK_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cyc_start  (cyc_start),
   .static_en  (static_en),
   .static_sel (static_sel),
   .pin_lvl    (pin_lvl),
   .pin_oe     (pin_oe),
   .dir_q      (dir_q),
   .tick       (tick));

// File: tb/pin_wave_fmt_tb_top.sv
`timescale 1ns/1ps
module pin_wave_fmt_tb_top;

   localparam int TW  = 8;
   localparam int PN  = 4;
   localparam int LEN = 12;

   typedef struct packed {
      logic [2:0] fmt;
      logic       dir;
      logic       data;
      logic [1:0] asel;
      logic [1:0] rsel;
      logic [1:0] e_pre;   // {oe,lvl} at tick 1
      logic [1:0] e_mid;   // tick 6
      logic [1:0] e_post;  // tick 10
   } vec_t;

   // phases: P0=2, P1=5, P2=8, P3=200 (beyond LEN)
   localparam vec_t TBL [15] = '{
      '{3'd0,1'b1,1'b1,2'd0,2'd2,2'b10,2'b11,2'b11}, // R5 hold 0 -> data 1
      '{3'd0,1'b1,1'b0,2'd0,2'd2,2'b11,2'b10,2'b10}, // R5 hold 1
      '{3'd1,1'b1,1'b0,2'd0,2'd2,2'b11,2'b10,2'b11}, // R6 return to 1
      '{3'd2,1'b1,1'b1,2'd0,2'd2,2'b10,2'b11,2'b10}, // R6 return to 0
      '{3'd3,1'b1,1'b1,2'd0,2'd2,2'b00,2'b11,2'b00}, // R7
      '{3'd4,1'b1,1'b1,2'd0,2'd2,2'b10,2'b11,2'b10}, // R8 complement
      '{3'd5,1'b1,1'b0,2'd0,2'd2,2'b11,2'b10,2'b11}, // R8 surround
      '{3'd1,1'b0,1'b0,2'd0,2'd2,2'b00,2'b00,2'b00}, // R4 input cycle
      '{3'd0,1'b1,1'b1,2'd0,2'd2,2'b10,2'b11,2'b11}, // R5 hold 0 survives input cycle
      '{3'd6,1'b1,1'b0,2'd0,2'd2,2'b11,2'b10,2'b10}, // R9 code 6
      '{3'd2,1'b1,1'b1,2'd1,2'd3,2'b10,2'b11,2'b11}, // R3 R12 return past length
      '{3'd1,1'b1,1'b0,2'd3,2'd0,2'b11,2'b11,2'b11}, // R12 assert never fires
      '{3'd0,1'b1,1'b0,2'd3,2'd0,2'b11,2'b11,2'b11}, // R5 held 1, data unused
      '{3'd3,1'b1,1'b1,2'd1,2'd1,2'b00,2'b00,2'b00}, // R7 empty window
      '{3'd7,1'b1,1'b0,2'd0,2'd2,2'b11,2'b10,2'b10}  // R9 code 7
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cyc_start;
   logic [TW-1:0] cyc_len;
   logic [PN*TW-1:0] phase_times;
   logic          cyc_data, cyc_out_en;
   logic [2:0]    cyc_fmt;
   logic [1:0]    cyc_asel, cyc_rsel;
   logic          static_en;
   logic [1:0]    static_sel;
   logic          pin_lvl, pin_oe;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;
   logic [1:0] rec [0:31];

   always #2.5 clk = ~clk;

   pin_wave_fmt #(.TICK_W(TW), .PHASE_N(PN)) dut_i (
      .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_len(cyc_len),
      .phase_times(phase_times), .cyc_data(cyc_data), .cyc_out_en(cyc_out_en),
      .cyc_fmt(cyc_fmt), .cyc_asel(cyc_asel), .cyc_rsel(cyc_rsel),
      .static_en(static_en), .static_sel(static_sel),
      .pin_lvl(pin_lvl), .pin_oe(pin_oe));

   task automatic chk(input string req, input string what,
                      input logic [1:0] act, input logic [1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual oe/lvl=%b expected=%b", req, what, act, exp);
      end
   endtask

   function automatic string req_of(input logic [2:0] f, input logic d);
      if (!d) return "R4";
      case (f)
         3'd0:       return "R5";
         3'd1, 3'd2: return "R6";
         3'd3:       return "R7";
         3'd4, 3'd5: return "R8";
         default:    return "R9";
      endcase
   endfunction

   // called at a negedge; records {oe,lvl} of ticks 0..len-1
   task automatic run_cycle(input logic [2:0] f, input logic d, input logic b,
                            input logic [1:0] a, input logic [1:0] r, input int len);
      cyc_fmt = f; cyc_out_en = d; cyc_data = b;
      cyc_asel = a; cyc_rsel = r; cyc_len = TW'(len);
      cyc_start = 1'b1;
      @(negedge clk);
      cyc_start = 1'b0;
      for (int t = 0; t < len; t++) begin
         @(negedge clk);
         rec[t] = {pin_oe, pin_lvl};
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; cyc_start = 1'b0; cyc_len = '0;
      phase_times = {8'd200, 8'd8, 8'd5, 8'd2};
      cyc_data = 1'b0; cyc_out_en = 1'b0; cyc_fmt = '0;
      cyc_asel = '0; cyc_rsel = '0; static_en = 1'b0; static_sel = '0;
      repeat (3) @(negedge clk);
      chk("R1", "in reset", {pin_oe, pin_lvl}, 2'b00);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1", "after reset", {pin_oe, pin_lvl}, 2'b00);

      for (int i = 0; i < 15; i++) begin
         run_cycle(TBL[i].fmt, TBL[i].dir, TBL[i].data, TBL[i].asel, TBL[i].rsel, LEN);
         chk(req_of(TBL[i].fmt, TBL[i].dir), $sformatf("vec %0d tick 1", i),  rec[1],  TBL[i].e_pre);
         chk(req_of(TBL[i].fmt, TBL[i].dir), $sformatf("vec %0d tick 6", i),  rec[6],  TBL[i].e_mid);
         chk(req_of(TBL[i].fmt, TBL[i].dir), $sformatf("vec %0d tick 10", i), rec[10], TBL[i].e_post);
      end

      // R2 R3: exact edge ticks, return to 0, assert P0=2, return P1=5
      run_cycle(3'd2, 1'b1, 1'b1, 2'd0, 2'd1, LEN);
      chk("R2", "tick before assert", rec[1], 2'b10);
      chk("R3", "tick at assert",     rec[2], 2'b11);
      chk("R3", "tick before return", rec[4], 2'b11);
      chk("R2", "tick at return",     rec[5], 2'b10);

      // R12: edge time equal to length never fires, one tick more and it does
      run_cycle(3'd1, 1'b1, 1'b0, 2'd1, 2'd3, 5);
      chk("R12", "edge equals length", rec[4], 2'b11);
      run_cycle(3'd1, 1'b1, 1'b0, 2'd1, 2'd3, 6);
      chk("R12", "edge below length before", rec[4], 2'b11);
      chk("R12", "edge below length fires",  rec[5], 2'b10);

      // R10 R11: static levels
      static_en = 1'b1; static_sel = 2'b01;
      @(negedge clk); @(negedge clk);
      chk("R10", "static high", {pin_oe, pin_lvl}, 2'b11);
      run_cycle(3'd3, 1'b1, 1'b0, 2'd0, 2'd2, LEN);
      chk("R10", "cycle ignored in static", rec[6], 2'b11);
      chk("R10", "cycle ignored in static", rec[1], 2'b11);
      static_sel = 2'b00;
      @(negedge clk); @(negedge clk);
      chk("R10", "static low", {pin_oe, pin_lvl}, 2'b10);
      static_sel = 2'b10;
      @(negedge clk); @(negedge clk);
      chk("R11", "static hi-Z quiet", {pin_oe, pin_lvl}, 2'b00);
      static_sel = 2'b11;
      @(negedge clk); @(negedge clk);
      chk("R10", "static hi-Z code 11", {pin_oe, pin_lvl}, 2'b00);
      static_en = 1'b0;

      // R4 R11: input cycle after static, level quiet
      run_cycle(3'd4, 1'b0, 1'b1, 2'd0, 2'd2, LEN);
      chk("R4", "input cycle tick 6", rec[6], 2'b00);
      chk("R11", "input cycle quiet", rec[0], 2'b00);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule